// File: doc/BRIEF.md
# Dual-Clock FIFO with Registered Read Port

This block moves data words from one clock domain into another, unrelated one. A producer in the write domain pushes words while the full flag is low. A consumer in the read domain pops words while the empty flag is low. Each domain has its own synchronous reset, which must already be aligned to that domain's clock. The two pointers carry one extra wrap bit. Each pointer crosses to the other domain as a Gray code through a chain of flip-flops. The flags are computed locally, from the local pointer and the synchronized copy of the far pointer.

The read output is a register clocked by the read clock, not a combinational selection from storage. On every read edge at which the FIFO is not empty, that register loads the entry at the current read address. A pop at that same edge therefore shows the popped word on the output for the cycle that follows. While the FIFO is not empty and no pop occurs, the output shows the word at the head of the queue. The output is meaningful only while empty is low.

Top module: `xclk_fifo`

## Requirements
- R1: On a read-clock edge where `rd_empty` is low, `rd_data` loads the word at the read address. After an edge that accepts a pop, `rd_data` holds the popped word. While no pop occurs and the FIFO is not empty, it shows the head word.
- R2: While `rd_rst` is high, `rd_data` is cleared to zero at each read edge. After both resets, `rd_empty` is 1 and `wr_full` is 0.
- R3: While `rd_empty` is high, `rd_data` keeps its value across read edges.
- R4: Every accepted word leaves the FIFO once, in the order written, with no loss and no duplication. This holds with the read clock faster than, slower than, or close to the write clock.
- R5: A push while `wr_full` is high is ignored: the storage and the write pointer keep their state, and the word never appears at the output.
- R6: A pop while `rd_empty` is high is ignored: the read pointer does not move, so the next word written is the next word read.
- R7: Each pointer changes by at most one Gray bit per clock. Order is preserved across many wraps of the address space.
- R8: `wr_full` rises at the edge of the 2^ADDR_W-th write with nothing read, and not before. The flags are never optimistic: not-full implies free space, and not-empty implies stored data.
- R9: The flags release only after the far pointer has crossed the two-stage synchronizer. With default parameters, both `rd_empty` falling after a write and `wr_full` falling after a pop take between 2 and 5 clocks of the observing domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_push | input | 1 | Request to store `wr_data` |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | No free entry as seen from the write domain |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_pop | input | 1 | Request to consume the head word |
| rd_data | output | DATA_W | Registered read word |
| rd_empty | output | 1 | No stored word as seen from the read domain |

## Verification
A corrupted pointer or a mis-synchronized Gray copy shows at the ports within a few clocks. It appears as a word out of order or repeated on `rd_data`, or as a flag that rises early or falls late. The reference queue catches any of these on the first affected pop. Flags that are too optimistic let a push overwrite unread data, which appears DEPTH words later as a wrong value. Flags that are too lazy appear as release latencies outside the bounds in R9. Runs with the read clock at several ratios to the write clock exercise both the full-bound and the empty-bound cases.

// File: rtl/xcf_sync.sv
`timescale 1ns/1ps
// Multi-stage flop synchronizer for a Gray-coded bus.
module xcf_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/xcf_gray_ptr.sv
`timescale 1ns/1ps
// Binary + Gray pointer pair with one extra wrap bit.
module xcf_gray_ptr #(
  parameter int ADDR_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step,
  output logic [ADDR_W:0] bin_q,
  output logic [ADDR_W:0] gray_q,
  output logic [ADDR_W:0] gray_nxt
);
  logic [ADDR_W:0] bin_nxt;

  always_comb begin
    bin_nxt  = bin_q + {{ADDR_W{1'b0}}, step};
    gray_nxt = bin_nxt ^ (bin_nxt >> 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_nxt;
      gray_q <= gray_nxt;
    end
  end

  // R7
  gray_one_bit_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(gray_q ^ $past(gray_q)) <= 1);
endmodule

// File: rtl/xcf_store.sv
`timescale 1ns/1ps
// Two-clock register array with a registered, enabled read port.
module xcf_store #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_word,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (wr_en) mem[wr_addr] <= wr_word;
  end

  always_ff @(posedge rd_clk) begin
    if (rd_rst)     rd_q <= '0;
    else if (rd_en) rd_q <= mem[rd_addr];
  end

  // R2
  rd_reset_clear_chk: assert property (@(posedge rd_clk)
    rd_rst |=> (rd_q == '0));
endmodule

// File: rtl/xclk_fifo.sv
`timescale 1ns/1ps
// Dual-clock FIFO: Gray pointers, two-flop crossings, registered read data.
module xclk_fifo #(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              wr_push,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_pop,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty
);
  localparam int              PW        = ADDR_W + 1;
  localparam int              DEPTH     = 1 << ADDR_W;
  localparam logic [ADDR_W:0] DEPTH_P   = PW'(DEPTH);
  localparam logic [ADDR_W:0] FULL_FLIP = {2'b11, {(ADDR_W-1){1'b0}}};

  logic [ADDR_W:0] w_bin, w_gray, w_gray_nxt, rq_gray;
  logic [ADDR_W:0] r_bin, r_gray, r_gray_nxt, wq_gray;
  logic            full_q, empty_q;
  logic            w_step, r_step;

  assign w_step = wr_push & ~full_q;
  assign r_step = rd_pop & ~empty_q;

  // ---------------- write domain ----------------
  xcf_gray_ptr #(.ADDR_W(ADDR_W)) u_wptr (
    .clk(wr_clk), .rst(wr_rst), .step(w_step),
    .bin_q(w_bin), .gray_q(w_gray), .gray_nxt(w_gray_nxt)
  );

  xcf_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_rd2wr (
    .clk(wr_clk), .rst(wr_rst), .d(r_gray), .q(rq_gray)
  );

  always_ff @(posedge wr_clk) begin
    if (wr_rst) full_q <= 1'b0;
    else        full_q <= (w_gray_nxt == (rq_gray ^ FULL_FLIP));
  end

  // ---------------- read domain ----------------
  xcf_gray_ptr #(.ADDR_W(ADDR_W)) u_rptr (
    .clk(rd_clk), .rst(rd_rst), .step(r_step),
    .bin_q(r_bin), .gray_q(r_gray), .gray_nxt(r_gray_nxt)
  );

  xcf_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_wr2rd (
    .clk(rd_clk), .rst(rd_rst), .d(w_gray), .q(wq_gray)
  );

  always_ff @(posedge rd_clk) begin
    if (rd_rst) empty_q <= 1'b1;
    else        empty_q <= (r_gray_nxt == wq_gray);
  end

  // ---------------- storage ----------------
  xcf_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .wr_clk(wr_clk), .wr_en(w_step), .wr_addr(w_bin[ADDR_W-1:0]), .wr_word(wr_data),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(~empty_q),
    .rd_addr(r_bin[ADDR_W-1:0]), .rd_q(rd_data)
  );

  assign wr_full  = full_q;
  assign rd_empty = empty_q;

  function automatic logic [ADDR_W:0] g2b(input logic [ADDR_W:0] g);
    logic [ADDR_W:0] b;
    b[ADDR_W] = g[ADDR_W];
    for (int i = ADDR_W - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // R5
  push_when_full_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (wr_full && wr_push) |=> $stable(w_gray));
  // R6
  pop_when_empty_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rd_empty && rd_pop) |=> $stable(r_gray));
  // R3
  hold_when_empty_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_empty |=> $stable(rd_data));
  // R8
  wr_occupancy_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (w_bin - g2b(rq_gray)) <= DEPTH_P);
  // R8
  full_pessimistic_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
    !wr_full |-> ((w_bin - g2b(rq_gray)) != DEPTH_P));
  // R8
  empty_pessimistic_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !rd_empty |-> (g2b(wq_gray) != r_bin));
endmodule

// File: tb/xclk_fifo_bench.sv
`timescale 1ns/1ps
module xclk_fifo_bench;
  localparam int DW    = 16;
  localparam int AW    = 3;
  localparam int DEPTH = 1 << AW;

  // row: [31:16] read half period in 10 ps, [15:12] push mask, [11:8] pop mask, [7:0] words
  localparam logic [31:0] ROWS [5] = '{
    {16'd250,  4'hF, 4'hF, 8'd40},   // read clock faster
    {16'd850,  4'hF, 4'hF, 8'd40},   // read clock slower, fills to full
    {16'd410,  4'h5, 4'h3, 8'd30},
    {16'd1130, 4'hF, 4'h9, 8'd30},
    {16'd330,  4'h3, 4'hF, 8'd30}
  };

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_rst = 1'b1, rd_rst = 1'b1;
  logic wr_push = 1'b0, rd_pop = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic wr_full, rd_empty;
  real  rd_half = 3.1;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [DW-1:0] refq [$];

  always #4 wr_clk = ~wr_clk;
  always #(rd_half) rd_clk = ~rd_clk;

  xclk_fifo #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2)) u_xclk_fifo (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_push(wr_push), .wr_data(wr_data), .wr_full(wr_full),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_pop(rd_pop), .rd_data(rd_data), .rd_empty(rd_empty)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_writer(input int n, input logic [3:0] mask, input logic [7:0] tag);
    int sent = 0;
    int cyc = 0;
    while (sent < n) begin
      @(negedge wr_clk);
      if (mask[cyc % 4]) begin
        wr_push = 1'b1;
        wr_data = {tag, 8'(sent)};
        if (!wr_full) begin
          refq.push_back(wr_data);
          sent++;
        end
      end else wr_push = 1'b0;
      cyc++;
    end
    @(negedge wr_clk);
    wr_push = 1'b0;
  endtask

  task automatic run_reader(input int n, input logic [3:0] mask, input string req);
    int got = 0;
    int cyc = 0;
    bit took = 1'b0;
    logic [DW-1:0] exp;
    while (got < n) begin
      @(negedge rd_clk);
      if (took) begin
        if (refq.size() == 0) chk(1'b0, req, rd_data, 0);
        else begin
          exp = refq.pop_front();
          chk(rd_data == exp, req, rd_data, exp);
        end
        got++;
      end
      if (mask[cyc % 4] && got < n) begin
        rd_pop = 1'b1;
        took = !rd_empty;
      end else begin
        rd_pop = 1'b0;
        took = 1'b0;
      end
      cyc++;
    end
    rd_pop = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] held;
    int k;
    repeat (5) @(negedge wr_clk);
    wr_rst = 1'b0;
    repeat (5) @(negedge rd_clk);
    rd_rst = 1'b0;
    @(negedge rd_clk);
    chk(rd_empty == 1'b1, "R2 empty after reset", rd_empty, 1);
    chk(rd_data == '0, "R2 data after reset", rd_data, 0);
    chk(wr_full == 1'b0, "R2 full after reset", wr_full, 0);

    // Table walk: R4 and R7 (many pointer wraps, both speed orders)
    for (int r = 0; r < 5; r++) begin
      rd_half = real'(ROWS[r][31:16]) / 100.0;
      repeat (3) @(negedge rd_clk);
      fork
        run_writer(int'(ROWS[r][7:0]), ROWS[r][15:12], 8'(r + 1));
        run_reader(int'(ROWS[r][7:0]), ROWS[r][11:8], "R4/R7 order");
      join
      repeat (6) @(negedge rd_clk);
      chk(rd_empty == 1'b1, "R4 drained", rd_empty, 1);
      chk(refq.size() == 0, "R4 no leftover", refq.size(), 0);
    end

    // Directed: fill with reader idle (R8), peek head (R1)
    rd_half = 5.0;
    repeat (3) @(negedge rd_clk);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge wr_clk);
      chk(wr_full == 1'b0, "R8 not full early", wr_full, 0);
      wr_push = 1'b1;
      wr_data = 16'hC000 + 16'(i);
      refq.push_back(wr_data);
    end
    @(negedge wr_clk);
    wr_push = 1'b0;
    chk(wr_full == 1'b1, "R8 full at depth", wr_full, 1);
    repeat (6) @(negedge rd_clk);
    chk(rd_data == 16'hC000, "R1 head peek", rd_data, 16'hC000);

    // R5: pushes while full are dropped
    @(negedge wr_clk);
    wr_push = 1'b1;
    wr_data = 16'hDEAD;
    repeat (3) @(negedge wr_clk);
    wr_push = 1'b0;
    chk(wr_full == 1'b1, "R5 still full", wr_full, 1);

    // One pop, then count full release latency (R9)
    @(negedge rd_clk);
    rd_pop = 1'b1;
    @(negedge rd_clk);
    rd_pop = 1'b0;
    held = refq.pop_front();
    chk(rd_data == held, "R1 popped word", rd_data, held);
    k = 0;
    while (wr_full && k < 20) begin
      @(negedge wr_clk);
      k++;
    end
    chk(k >= 2 && k <= 5, "R9 full release", k, 5);

    // Drain rest: DEAD must not appear (R5)
    run_reader(DEPTH - 1, 4'hF, "R5 drain order");
    repeat (5) @(negedge rd_clk);
    chk(rd_empty == 1'b1, "R5 empty after drain", rd_empty, 1);

    // R3/R6: pops while empty
    held = rd_data;
    rd_pop = 1'b1;
    repeat (4) @(negedge rd_clk);
    rd_pop = 1'b0;
    chk(rd_data == held, "R3 hold while empty", rd_data, held);
    chk(rd_empty == 1'b1, "R6 still empty", rd_empty, 1);

    // One write: empty release latency (R9), then pointer unchanged (R6)
    @(negedge wr_clk);
    wr_push = 1'b1;
    wr_data = 16'h5A5A;
    refq.push_back(wr_data);
    @(negedge wr_clk);
    wr_push = 1'b0;
    k = 0;
    while (rd_empty && k < 20) begin
      @(negedge rd_clk);
      k++;
    end
    chk(k >= 2 && k <= 5, "R9 empty release", k, 5);
    run_reader(1, 4'hF, "R6 next word");

    // R2: reset clears read data
    @(negedge wr_clk);
    wr_rst = 1'b1;
    @(negedge rd_clk);
    rd_rst = 1'b1;
    repeat (3) @(negedge rd_clk);
    chk(rd_data == '0, "R2 cleared by reset", rd_data, 0);
    chk(rd_empty == 1'b1, "R2 empty in reset", rd_empty, 1);
    chk(wr_full == 1'b0, "R2 not full in reset", wr_full, 0);
    rd_rst = 1'b0;
    @(negedge wr_clk);
    wr_rst = 1'b0;
    repeat (3) @(negedge wr_clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule